// File: doc/BRIEF.md
# Dual-Instruction Fetch Unit

This block is the front of a narrow in-order pipeline that reads two 16-bit instructions at a time. It keeps a fetch address that starts at a configurable code-segment base and moves forward by one 4-byte pair each time the pipeline can accept more work. That address goes to a synchronous instruction memory port. The 32-bit word comes back one cycle later and is split into two decode slots. Each slot carries its own keep bit, and the pair as a whole carries a valid/ready handshake toward decode.

The block looks only at the opcode field of the first slot. If that slot holds a branch, the second slot of the same pair is marked as not kept, which leaves a bubble in that lane. The branch target is not computed here. The branch unit supplies it on a redirect input, which reloads the fetch address and throws away the pair already requested from memory.

Decode applies back-pressure by holding `dec_ready` low. While `dec_valid` is high and `dec_ready` is low, the presented pair and its address stay fixed, and no new memory read is issued. A pair is consumed on the first clock edge where `dec_valid` and `dec_ready` are both high. Once `dec_valid` has been raised, it never drops without a handshake.

Top module: `fetch2_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `dec_valid` is 0. On that first cycle `imem_en` is 1 and `imem_addr` equals the base address with its two low bits cleared.
- R2: Every memory read is issued at the previous read address plus 4. In a presented pair, `dec_slot0_instr` is `imem_rdata[15:0]`, the instruction at byte address `dec_pc`. `dec_slot1_instr` is `imem_rdata[31:16]`, the instruction at `dec_pc + 2`.
- R3: `imem_addr` always has bits [1:0] equal to 0. The low two bits of `redirect_target` are ignored.
- R4: Whenever `dec_valid` is 1, `dec_slot0_ok` is 1.
- R5: An instruction is a branch when its bits [15:12] equal `BR_OPCODE` (default 4'hB). A presented pair whose slot 0 is a branch has `dec_slot1_ok` = 0; otherwise `dec_slot1_ok` = 1. A branch opcode in slot 1 has no effect on either slot.
- R6: While `dec_valid` = 1 and `dec_ready` = 0, `imem_en` is 0, and on the next cycle `dec_valid`, `dec_pc` and both slots are unchanged.
- R7: A redirect sampled at a clock edge makes the next memory read use the aligned target, and no pair that was requested before the redirect is presented afterwards. A pair that was already presented and stalled at the redirect stays presented until it is accepted.
- R8: With `dec_ready` held at 1 and no redirect, a new pair is presented on every cycle from the second cycle after the pipeline starts, in increasing address order with no pair skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_en | output | 1 | Instruction memory read enable; when low the memory keeps its last output |
| imem_addr | output | AW | Byte address of the pair being read, 4-byte aligned |
| imem_rdata | input | 32 | Pair word returned one cycle after the read; low half is the lower address |
| redirect_valid | input | 1 | Load a new fetch address |
| redirect_target | input | AW | New fetch byte address |
| dec_valid | output | 1 | A pair is presented to decode |
| dec_ready | input | 1 | Decode accepts the presented pair |
| dec_pc | output | AW | Byte address of slot 0 |
| dec_slot0_ok | output | 1 | Slot 0 holds a live instruction |
| dec_slot0_instr | output | 16 | Slot 0 instruction |
| dec_slot1_ok | output | 1 | Slot 1 holds a live instruction (cleared behind a branch) |
| dec_slot1_instr | output | 16 | Slot 1 instruction |

## Verification
Several properties are checked on every cycle. These are the alignment of every read address, the 4-byte step between successive reads, the reload of the address after a redirect, the freezing of the presented pair and of the memory enable under back-pressure, and the clearing of slot 1 behind a branch in slot 0. The bench is needed for the ordering properties. Only its scenarios show that the stream of accepted pairs matches the instruction image address by address, that a dropped in-flight pair never surfaces after a redirect, and that a pair stalled across a redirect is still delivered before the first pair from the target. The same applies to an uninterrupted stream producing one pair per cycle.

// File: rtl/fetch2_pkg.sv
package fetch2_pkg;
  localparam int unsigned ILEN       = 16;
  localparam int unsigned NSLOT      = 2;
  localparam int unsigned OPC_W      = 4;
  localparam int unsigned FETCH_W    = ILEN * NSLOT;
  localparam int unsigned PAIR_BYTES = FETCH_W / 8;

  typedef logic [ILEN-1:0] instr_t;

  typedef struct packed {
    logic   ok;
    instr_t instr;
  } slot_t;
endpackage

// File: rtl/f2_pc_gen.sv
module f2_pc_gen
  import fetch2_pkg::*;
#(
  parameter int unsigned    AW        = 16,
  parameter logic [AW-1:0]  BASE_ADDR = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          redirect_valid,
  input  logic [AW-1:0] redirect_target,
  output logic          imem_en,
  output logic [AW-1:0] imem_addr,
  output logic          inflight_valid,
  output logic [AW-1:0] inflight_pc
);
  localparam logic [AW-1:0] STEP       = AW'(PAIR_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = ~(STEP - AW'(1));
  localparam logic [AW-1:0] RESET_PC   = BASE_ADDR & ALIGN_MASK;

  logic [AW-1:0] pc_q;

  // a redirect cycle issues no read: its address would be wrong-path
  assign imem_en   = advance && !redirect_valid;
  assign imem_addr = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q           <= RESET_PC;
      inflight_valid <= 1'b0;
      inflight_pc    <= RESET_PC;
    end else if (redirect_valid) begin
      pc_q           <= redirect_target & ALIGN_MASK;
      inflight_valid <= 1'b0;
    end else if (advance) begin
      pc_q           <= pc_q + STEP;
      inflight_valid <= 1'b1;
      inflight_pc    <= pc_q;
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_en |-> ((imem_addr & ~ALIGN_MASK) == '0)) else $error("misaligned read"); // R3

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    imem_en |=> (pc_q == $past(pc_q) + STEP)) else $error("bad fetch step"); // R2

  AST_REDIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (pc_q == ($past(redirect_target) & ALIGN_MASK)) && !inflight_valid)
    else $error("redirect not taken"); // R7
endmodule

// File: rtl/f2_branch_detect.sv
module f2_branch_detect
  import fetch2_pkg::*;
#(
  parameter logic [OPC_W-1:0] BR_OPCODE = 4'hB
) (
  input  logic [FETCH_W-1:0] fetch_word,
  output slot_t [NSLOT-1:0]  slots
);
  logic [NSLOT-1:0] is_branch;
  logic [NSLOT-1:0] keep;

  for (genvar i = 0; i < NSLOT; i++) begin : g_lane
    instr_t lane_instr;
    assign lane_instr   = fetch_word[i*ILEN +: ILEN];
    assign is_branch[i] = (lane_instr[ILEN-1 -: OPC_W] == BR_OPCODE);

    if (i == 0) begin : g_head
      assign keep[i] = 1'b1;
    end else begin : g_tail
      // a lane survives only if no older lane in the group branches away
      assign keep[i] = keep[i-1] & ~is_branch[i-1];
    end

    assign slots[i].ok    = keep[i];
    assign slots[i].instr = lane_instr;
  end
endmodule

// File: rtl/f2_slot_reg.sv
module f2_slot_reg
  import fetch2_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_valid,
  input  logic [AW-1:0]     in_pc,
  input  slot_t [NSLOT-1:0] in_slots,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [AW-1:0]     out_pc,
  output slot_t [NSLOT-1:0] out_slots
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pc    <= '0;
      out_slots <= '0;
    end else if (load) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pc    <= in_pc;
        out_slots <= in_slots;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_pc) && $stable(out_slots))
    else $error("presented pair changed under stall"); // R6
endmodule

// File: rtl/fetch2_unit.sv
module fetch2_unit
  import fetch2_pkg::*;
#(
  parameter int unsigned       AW        = 16,
  parameter logic [AW-1:0]     BASE_ADDR = 16'h0100,
  parameter logic [OPC_W-1:0]  BR_OPCODE = 4'hB
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               imem_en,
  output logic [AW-1:0]      imem_addr,
  input  logic [FETCH_W-1:0] imem_rdata,
  input  logic               redirect_valid,
  input  logic [AW-1:0]      redirect_target,
  output logic               dec_valid,
  input  logic               dec_ready,
  output logic [AW-1:0]      dec_pc,
  output logic               dec_slot0_ok,
  output logic [ILEN-1:0]    dec_slot0_instr,
  output logic               dec_slot1_ok,
  output logic [ILEN-1:0]    dec_slot1_instr
);
  logic              advance;
  logic              inflight_valid;
  logic [AW-1:0]     inflight_pc;
  slot_t [NSLOT-1:0] lane_slots;
  slot_t [NSLOT-1:0] held_slots;

  // the output register can take a new pair when empty or being consumed
  assign advance = !dec_valid || dec_ready;

  f2_pc_gen #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_pc (
    .clk             (clk),
    .rst_n           (rst_n),
    .advance         (advance),
    .redirect_valid  (redirect_valid),
    .redirect_target (redirect_target),
    .imem_en         (imem_en),
    .imem_addr       (imem_addr),
    .inflight_valid  (inflight_valid),
    .inflight_pc     (inflight_pc)
  );

  f2_branch_detect #(.BR_OPCODE(BR_OPCODE)) u_br (
    .fetch_word (imem_rdata),
    .slots      (lane_slots)
  );

  f2_slot_reg #(.AW(AW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (advance),
    .in_valid  (inflight_valid && !redirect_valid),
    .in_pc     (inflight_pc),
    .in_slots  (lane_slots),
    .out_ready (dec_ready),
    .out_valid (dec_valid),
    .out_pc    (dec_pc),
    .out_slots (held_slots)
  );

  assign dec_slot0_ok    = held_slots[0].ok;
  assign dec_slot0_instr = held_slots[0].instr;
  assign dec_slot1_ok    = held_slots[1].ok;
  assign dec_slot1_instr = held_slots[1].instr;

  AST_SLOT0_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_slot0_ok) else $error("slot 0 dead"); // R4

  AST_BRANCH_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (dec_slot0_instr[ILEN-1 -: OPC_W] == BR_OPCODE)) |-> !dec_slot1_ok)
    else $error("slot 1 kept behind branch"); // R5

  AST_STALL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> !imem_en) else $error("read under stall"); // R6

  AST_REDIRECT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && (!dec_valid || dec_ready)) |=> !dec_valid)
    else $error("in-flight pair survived redirect"); // R7
endmodule

// File: tb/tb_fetch2_unit.sv
module tb_fetch2_unit;
  localparam int unsigned AW   = 16;
  localparam logic [15:0] BASE = 16'h0100;
  localparam logic [3:0]  BR   = 4'hB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_en;
  logic [15:0] imem_addr;
  logic [31:0] imem_rdata = '0;
  logic        redirect_valid = 1'b0;
  logic [15:0] redirect_target = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic [15:0] dec_pc;
  logic        dec_slot0_ok, dec_slot1_ok;
  logic [15:0] dec_slot0_instr, dec_slot1_instr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fetch2_unit #(.AW(AW), .BASE_ADDR(BASE), .BR_OPCODE(BR)) dut (
    .clk(clk), .rst_n(rst_n), .imem_en(imem_en), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .redirect_valid(redirect_valid),
    .redirect_target(redirect_target), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_pc(dec_pc), .dec_slot0_ok(dec_slot0_ok), .dec_slot0_instr(dec_slot0_instr),
    .dec_slot1_ok(dec_slot1_ok), .dec_slot1_instr(dec_slot1_instr)
  );

  // instruction image: branches at byte offsets 0 mod 16 (slot 0) and 10 mod 16 (slot 1)
  function automatic logic [15:0] instr_at(input logic [15:0] a);
    logic [3:0] op;
    op = a[6:3];
    if (op == BR) op = 4'h1;
    if (a[3:1] == 3'd0 || a[3:1] == 3'd5) op = BR;
    return {op, a[11:0]};
  endfunction

  function automatic bit is_br(input logic [15:0] ins);
    return ins[15:12] == BR;
  endfunction

  always_ff @(posedge clk)
    if (imem_en) imem_rdata <= {instr_at(imem_addr + 16'd2), instr_at(imem_addr)};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [15:0] exp_pc = BASE;
  logic [15:0] exp_after = '0;
  bit          held_old = 0;
  bit          after_redir = 0;
  bit          stall_prev = 0;
  logic [15:0] h_pc, h_s0, h_s1;
  logic        h_ok1;
  int          accepted = 0;

  task automatic do_cycle(input bit rdy, input bit rv, input logic [15:0] tgt);
    bit hs;
    @(negedge clk);
    dec_ready = rdy;
    redirect_valid = rv;
    redirect_target = tgt;
    #1;
    if (stall_prev) begin
      chk(dec_valid && dec_pc == h_pc && dec_slot0_instr == h_s0 &&
          dec_slot1_instr == h_s1 && dec_slot1_ok == h_ok1, "R6 hold",
          {dec_pc, dec_slot0_instr}, {h_pc, h_s0});
    end
    if (dec_valid && !rdy) chk(!imem_en, "R6 no read", imem_en, 0);
    if (imem_en) chk(imem_addr[1:0] == 2'b00, "R3 align", imem_addr, imem_addr & 16'hFFFC);
    hs = dec_valid && rdy;
    if (hs) begin
      chk(dec_pc == exp_pc, after_redir ? "R7 target pc" : "R8 order pc", dec_pc, exp_pc);
      chk(dec_slot0_instr == instr_at(exp_pc) && dec_slot0_ok, "R2/R4 slot0",
          {dec_slot0_ok, dec_slot0_instr}, {1'b1, instr_at(exp_pc)});
      chk(dec_slot1_instr == instr_at(exp_pc + 16'd2), "R2 slot1",
          dec_slot1_instr, instr_at(exp_pc + 16'd2));
      chk(dec_slot1_ok == !is_br(instr_at(exp_pc)), "R5 squash",
          dec_slot1_ok, !is_br(instr_at(exp_pc)));
      accepted++;
      after_redir = 0;
      if (held_old) begin
        exp_pc = exp_after;
        held_old = 0;
        after_redir = 1;
      end else exp_pc = exp_pc + 16'd4;
    end
    if (rv) begin
      if (dec_valid && !rdy) begin
        held_old = 1;
        exp_after = tgt & 16'hFFFC;
      end else begin
        exp_pc = tgt & 16'hFFFC;
        held_old = 0;
        after_redir = 1;
      end
    end
    stall_prev = dec_valid && !rdy;
    h_pc = dec_pc; h_s0 = dec_slot0_instr; h_s1 = dec_slot1_instr; h_ok1 = dec_slot1_ok;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(!dec_valid, "R1 reset valid", dec_valid, 0);
    rst_n = 1'b1;
    #1;
    chk(!dec_valid && imem_en && imem_addr == BASE, "R1 first read",
        {dec_valid, imem_en, imem_addr}, {2'b01, BASE});

    // R8: free-running stream
    for (int i = 0; i < 40; i++) begin
      do_cycle(1'b1, 1'b0, '0);
      if (i >= 1) chk(dec_valid, "R8 one pair per cycle", dec_valid, 1);
    end
    // R6: stall
    for (int i = 0; i < 5; i++) do_cycle(1'b0, 1'b0, '0);
    do_cycle(1'b1, 1'b0, '0);
    // R3/R7: redirect with low bits set, while flowing
    do_cycle(1'b1, 1'b1, 16'h0203);
    for (int i = 0; i < 6; i++) do_cycle(1'b1, 1'b0, '0);
    // R7: redirect while stalled
    do_cycle(1'b0, 1'b0, '0);
    do_cycle(1'b0, 1'b1, 16'h0412);
    do_cycle(1'b0, 1'b0, '0);
    for (int i = 0; i < 6; i++) do_cycle(1'b1, 1'b0, '0);
    // R5: slot-1 branch (offset 10) and slot-0 branch (offset 0) covered
    do_cycle(1'b1, 1'b1, 16'h0808);
    for (int i = 0; i < 6; i++) do_cycle(1'b1, 1'b0, '0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit r, v;
      r = ($urandom % 4) != 0;
      v = ($urandom % 16) == 0;
      do_cycle(r, v, 16'($urandom));
    end
    for (int i = 0; i < 10; i++) do_cycle(1'b1, 1'b0, '0);
    chk(accepted > 1000, "R8 progress", accepted, 1000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule